// File: doc/BRIEF.md
# Serial EEPROM Slave Bus Front End

This block is the two-wire bus side of a 64-kbit byte-addressed serial EEPROM. Its address space is 8192 bytes. A fast system clock samples SCL and SDA. Each line passes a two-flop synchroniser and then a counter-based filter that removes short spikes. The block detects START, repeated START and STOP on the filtered lines.

After a START the block receives a device byte. The block acknowledges only when the byte carries its own family code and the three strap bits, and only while no program cycle is running. Because it stays silent while busy, a host can poll for the end of a program cycle by repeatedly addressing it. In a write, two word-address bytes load a 13-bit address counter, and each following data byte goes to the write path. In a read, bytes come from a behavioural byte array at the counter position. The counter advances after every byte in both directions. SDA is driven open-drain: the block only pulls it low or releases it.

The behavioural array holds 2^MEM_AW bytes and is indexed by the low bits of the 13-bit counter. A STOP that ends a transfer containing written data starts the program cycle in the sequencer. The sequencer sits outside this block and reports back on `prog_busy`.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset, SDA is released (`sda_oe` = 0), and `wr_stb` and `prog_start` are low.
- R2: The device byte holds family code 1010 in bits 7..4, the strap value in bits 3..1 and R/W in bit 0 (1 = read), sent MSB first. A match is acknowledged by pulling SDA low during the ninth clock. A mismatch is not acknowledged, and the block answers nothing more until the next START.
- R3: In a write, the high word-address byte comes first, then the low byte; only the low 13 bits are kept and the upper three are ignored. Each data byte is acknowledged and produces one `wr_stb` pulse carrying the counter value and the byte. The counter then increments and wraps from 8191 to 0.
- R4: In a read (R/W = 1), bytes are sent MSB first starting at the counter value. The counter increments after each byte and wraps from 8191 to 0.
- R5: When the host acknowledges a read byte (SDA low in the ninth clock), the next byte follows. When the host does not acknowledge, SDA stays released until the next START or STOP.
- R6: While `prog_busy` is high, the device byte is not acknowledged, SDA stays released, and data bytes that follow produce no write. The device byte is acknowledged again once `prog_busy` is low.
- R7: A STOP that ends a transfer with at least one data byte written gives exactly one `prog_start` pulse. A transfer with no data byte gives none.
- R8: A pulse on SCL or SDA shorter than FILT_CYCLES system clocks has no effect on the protocol.
- R9: `sda_oe` changes only while the filtered SCL is low, except for a release on START or STOP.
- R10: A repeated START without STOP restarts the device byte phase, so a write of the word address followed by a read returns data from that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap | input | 3 | Device address strap bits |
| prog_busy | input | 1 | High while the program sequencer is busy |
| wr_stb | output | 1 | One-cycle pulse per received data byte |
| wr_addr | output | 13 | Word address of the byte on `wr_data` |
| wr_data | output | 8 | Received data byte |
| prog_start | output | 1 | One-cycle pulse on a STOP that ends a write transfer |

## Verification
The hardest case to reach is a spike that lands inside the high phase of SCL. On SCL it would add a bit to the shift register. On SDA it would look like a START or STOP in the middle of a byte. The bench's bit task can pull the line for three clocks halfway through the high phase. It does this on an SCL bit of the device byte and on a 1 bit of a data byte. It then checks that the ACK and the stored byte both come through intact. The wrap of the counter from 8191 to 0 is reached by writing the last address directly, with junk in the top three bits of the high address byte.

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int          ADDR_W      = 13,
  parameter int          MEM_AW      = 8,
  parameter int          FILT_CYCLES = 5,
  parameter logic [3:0]  FAMILY      = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        strap,
  input  logic              prog_busy,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              prog_start
);
  localparam int HI_W  = ADDR_W - 8;
  localparam int FC_W  = $clog2(FILT_CYCLES + 1);
  localparam int DEPTH = 1 << MEM_AW;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_AH, S_AL, S_WR, S_RD} st_t;

  // line index 1 = SCL, 0 = SDA
  logic [1:0]      m1, m2, filt, filt_q;
  logic [FC_W-1:0] fcnt [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 <= 2'b11; m2 <= 2'b11; filt <= 2'b11; filt_q <= 2'b11;
      for (int i = 0; i < 2; i++) fcnt[i] <= '0;
    end else begin
      m1     <= {scl_i, sda_i};
      m2     <= m1;
      filt_q <= filt;
      for (int i = 0; i < 2; i++) begin
        if (m2[i] == filt[i]) fcnt[i] <= '0;
        else if (fcnt[i] == FC_W'(FILT_CYCLES - 1)) begin
          filt[i] <= m2[i];
          fcnt[i] <= '0;
        end else fcnt[i] <= fcnt[i] + 1'b1;
      end
    end
  end

  wire scl_f   = filt[1];
  wire sda_f   = filt[0];
  wire scl_q   = filt_q[1];
  wire sda_q   = filt_q[0];
  wire start_c = scl_f & scl_q & sda_q & ~sda_f;
  wire stop_c  = scl_f & scl_q & ~sda_q & sda_f;
  wire rise    = scl_f & ~scl_q;
  wire fall    = ~scl_f & scl_q;

  st_t             st;
  logic [3:0]      bitcnt;
  logic            in_ack, rw, mnack, wrote;
  logic [7:0]      sr, tx;
  logic [HI_W-1:0] ahi;
  logic [ADDR_W-1:0] cnt;
  logic [7:0]      mem [DEPTH];

  wire [7:0] rd_data   = mem[cnt[MEM_AW-1:0]];
  wire       dev_hit   = (sr[7:1] == {FAMILY, strap});
  wire       byte_done = fall & ~in_ack & (bitcnt == 4'd8);
  wire       mem_we    = byte_done & (st == S_WR);

  always_ff @(posedge clk) begin
    if (mem_we) mem[cnt[MEM_AW-1:0]] <= sr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; bitcnt <= '0; in_ack <= 1'b0; rw <= 1'b0; mnack <= 1'b0;
      wrote <= 1'b0; sr <= '0; tx <= '0; ahi <= '0; cnt <= '0;
      sda_oe <= 1'b0; wr_stb <= 1'b0; wr_addr <= '0; wr_data <= '0; prog_start <= 1'b0;
    end else begin
      wr_stb     <= 1'b0;
      prog_start <= 1'b0;
      if (start_c) begin
        st <= S_DEV; bitcnt <= '0; in_ack <= 1'b0; sda_oe <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE; in_ack <= 1'b0; sda_oe <= 1'b0;
        prog_start <= wrote; wrote <= 1'b0;
      end else if (rise) begin
        if (st == S_RD) begin
          if (in_ack) mnack <= sda_f;
          else        bitcnt <= bitcnt + 1'b1;
        end else if (st != S_IDLE && !in_ack && bitcnt < 4'd8) begin
          sr     <= {sr[6:0], sda_f};
          bitcnt <= bitcnt + 1'b1;
        end
      end else if (fall) begin
        if (st == S_RD) begin
          if (in_ack) begin
            in_ack <= 1'b0;
            if (mnack) begin
              st <= S_IDLE; sda_oe <= 1'b0;
            end else begin
              tx <= rd_data << 1; sda_oe <= ~rd_data[7]; bitcnt <= '0;
            end
          end else if (bitcnt == 4'd8) begin
            sda_oe <= 1'b0; in_ack <= 1'b1; cnt <= cnt + 1'b1;
          end else begin
            sda_oe <= ~tx[7]; tx <= tx << 1;
          end
        end else if (st != S_IDLE) begin
          if (in_ack) begin
            in_ack <= 1'b0; bitcnt <= '0;
            if (st == S_DEV && rw) begin
              st <= S_RD; tx <= rd_data << 1; sda_oe <= ~rd_data[7];
            end else begin
              sda_oe <= 1'b0;
              case (st)
                S_DEV:   st <= S_AH;
                S_AH:    st <= S_AL;
                S_AL:    st <= S_WR;
                default: st <= st;
              endcase
            end
          end else if (bitcnt == 4'd8) begin
            case (st)
              S_DEV: begin
                if (dev_hit && !prog_busy) begin
                  sda_oe <= 1'b1; in_ack <= 1'b1; rw <= sr[0];
                end else st <= S_IDLE;
              end
              S_AH: begin
                ahi <= sr[HI_W-1:0]; sda_oe <= 1'b1; in_ack <= 1'b1;
              end
              S_AL: begin
                cnt <= {ahi, sr}; sda_oe <= 1'b1; in_ack <= 1'b1;
              end
              S_WR: begin
                wr_stb <= 1'b1; wr_addr <= cnt; wr_data <= sr; cnt <= cnt + 1'b1;
                wrote <= 1'b1; sda_oe <= 1'b1; in_ack <= 1'b1;
              end
              default: ;
            endcase
          end
        end
      end
    end
  end

  p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!$past(scl_f) || $past(start_c) || $past(stop_c)));

  p_busy_nack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && st == S_DEV && prog_busy) |=> (!sda_oe && st == S_IDLE));

  p_mismatch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && st == S_DEV && sr[7:1] != {FAMILY, strap}) |=> (!sda_oe && st == S_IDLE));

  p_wr_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (cnt == wr_addr + 1'b1));

  p_rd_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD && fall && !in_ack && bitcnt == 4'd8) |=> (cnt == $past(cnt) + 1'b1));

  p_pstart_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> $past(stop_c));
endmodule

// File: tb/tb_i2c_eeprom_slave.sv
module tb_i2c_eeprom_slave;
  localparam int CLK_NS = 10;
  localparam int Q      = 30;
  localparam int WDOG   = 190000;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, prog_busy = 1'b0;
  logic [2:0]  strap = 3'b101;
  logic        sda_oe, wr_stb, prog_start;
  logic [12:0] wr_addr;
  logic [7:0]  wr_data;
  wire         sda_line = sda_m & ~sda_oe;

  always #(CLK_NS/2) clk = ~clk;

  i2c_eeprom_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap(strap), .prog_busy(prog_busy), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .prog_start(prog_start));

  int checks = 0, fails = 0, wr_cnt = 0, ps_cnt = 0;
  logic [12:0] last_wa = '0;
  logic [7:0]  last_wd = '0;

  always @(posedge clk) begin
    if (wr_stb) begin wr_cnt++; last_wa <= wr_addr; last_wd <= wr_data; end
    if (prog_start) ps_cnt++;
  end

  localparam logic [20:0] TBL [6] = '{
    {13'h0000, 8'h5A}, {13'h00A5, 8'hC1}, {13'h1F10, 8'h7E},
    {13'h0033, 8'h00}, {13'h0FFE, 8'hFF}, {13'h1234, 8'h96}};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bstart();
    q(); sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0;
  endtask

  task automatic bstop();
    q(); sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic put_bit(input logic b, input int glitch);
    q(); sda_m = b; q(); scl_m = 1'b1; q();
    if (glitch == 1) begin scl_m = 1'b0; repeat (3) @(negedge clk); scl_m = 1'b1; end
    if (glitch == 2) begin sda_m = 1'b0; repeat (3) @(negedge clk); sda_m = b; end
    q(); scl_m = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    q(); sda_m = 1'b1; q(); scl_m = 1'b1; q(); b = sda_line; q(); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack, input int glitch, input int gbit);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i], (i == gbit) ? glitch : 0);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic nack);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(nack, 0);
  endtask

  function automatic logic [7:0] dev(input logic rd);
    return {4'b1010, strap, rd};
  endfunction

  // writes n bytes d0, d0+0x11, ... starting at a; junk in top 3 bits of high byte
  task automatic do_write(input logic [12:0] a, input logic [7:0] d0, input int n, output logic all_ack);
    logic ack;
    all_ack = 1'b1;
    bstart();
    send_byte(dev(1'b0), ack, 0, 0); all_ack &= ack;
    send_byte({3'b110, a[12:8]}, ack, 0, 0); all_ack &= ack;
    send_byte(a[7:0], ack, 0, 0); all_ack &= ack;
    for (int i = 0; i < n; i++) begin
      send_byte(d0 + 8'(i * 8'h11), ack, 0, 0); all_ack &= ack;
    end
    bstop();
  endtask

  task automatic read_chk(input logic [12:0] a, input logic [7:0] d0, input int n);
    logic ack, all_ack;
    logic [7:0] got;
    all_ack = 1'b1;
    bstart();
    send_byte(dev(1'b0), ack, 0, 0); all_ack &= ack;
    send_byte({3'b111, a[12:8]}, ack, 0, 0); all_ack &= ack;
    send_byte(a[7:0], ack, 0, 0); all_ack &= ack;
    bstart();
    send_byte(dev(1'b1), ack, 0, 0); all_ack &= ack;
    chk("R10 repeated start address phase acked", int'(all_ack), 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(got, (i == n - 1));
      chk("R4 read data", int'(got), int'(d0 + 8'(i * 8'h11)));
    end
    q();
    chk("R5 SDA released after host NACK", int'(sda_line), 1);
    bstop();
  endtask

  initial begin
    #(CLK_NS * WDOG);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic ok, ack;
    int w0, p0;
    repeat (20) @(negedge clk);
    chk("R1 sda_oe after reset", int'(sda_oe), 0);
    chk("R1 wr_stb after reset", int'(wr_stb), 0);
    chk("R1 prog_start after reset", int'(prog_start), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    foreach (TBL[k]) begin
      p0 = ps_cnt;
      do_write(TBL[k][20:8], TBL[k][7:0], 1, ok);
      repeat (4) @(negedge clk);
      chk("R3 write acked", int'(ok), 1);
      chk("R3 wr_addr", int'(last_wa), int'(TBL[k][20:8]));
      chk("R3 wr_data", int'(last_wd), int'(TBL[k][7:0]));
      chk("R7 one prog_start per write", ps_cnt - p0, 1);
    end
    foreach (TBL[k]) read_chk(TBL[k][20:8], TBL[k][7:0], 1);

    w0 = wr_cnt;
    do_write(13'h0040, 8'h11, 3, ok);
    repeat (4) @(negedge clk);
    chk("R3 multi-byte write acked", int'(ok), 1);
    chk("R3 three strobes", wr_cnt - w0, 3);
    chk("R3 counter increment", int'(last_wa), 'h42);
    read_chk(13'h0040, 8'h11, 3);

    do_write(13'h1FFF, 8'hC3, 2, ok);
    repeat (4) @(negedge clk);
    chk("R3 wrap write address", int'(last_wa), 0);
    chk("R3 wrap write data", int'(last_wd), 'hD4);
    p0 = ps_cnt;
    read_chk(13'h1FFF, 8'hC3, 2);
    chk("R7 no prog_start after read-only transfer", ps_cnt - p0, 0);

    bstart();
    send_byte({4'b1010, strap ^ 3'b001, 1'b0}, ack, 0, 0);
    chk("R2 strap mismatch not acked", int'(ack), 0);
    send_byte(8'h00, ack, 0, 0);
    chk("R2 silent after mismatch", int'(ack), 0);
    bstop();
    bstart();
    send_byte({4'b1011, strap, 1'b1}, ack, 0, 0);
    chk("R2 family mismatch not acked", int'(ack), 0);
    bstop();

    prog_busy = 1'b1;
    w0 = wr_cnt;
    bstart();
    send_byte(dev(1'b0), ack, 0, 0);
    chk("R6 busy write address not acked", int'(ack), 0);
    send_byte(8'h00, ack, 0, 0);
    send_byte(8'h40, ack, 0, 0);
    send_byte(8'hEE, ack, 0, 0);
    chk("R6 busy data not acked", int'(ack), 0);
    bstop();
    chk("R6 no write while busy", wr_cnt - w0, 0);
    bstart();
    send_byte(dev(1'b1), ack, 0, 0);
    chk("R6 busy read address not acked", int'(ack), 0);
    bstop();
    prog_busy = 1'b0;
    bstart();
    send_byte(dev(1'b0), ack, 0, 0);
    chk("R6 ack after busy clears", int'(ack), 1);
    bstop();
    read_chk(13'h0040, 8'h11, 1);

    bstart();
    send_byte(dev(1'b0), ack, 1, 3);
    chk("R8 SCL spike ignored", int'(ack), 1);
    send_byte(8'h00, ack, 0, 0);
    send_byte(8'h77, ack, 0, 0);
    send_byte(8'hA5, ack, 2, 7);
    chk("R8 SDA spike ignored", int'(ack), 1);
    bstop();
    repeat (4) @(negedge clk);
    chk("R8 data after spikes", int'(last_wd), 'hA5);
    read_chk(13'h0077, 8'hA5, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule